// File: doc/BRIEF.md
# Powerline Command Frame Handshake Controller

This block is the interface side of a host link that carries powerline commands. It watches a stream of received bytes for a valid frame header. It collects either a two-byte or a four-byte frame, depending on the header's extended-frame flag. It then returns the 8-bit modular sum of the frame bytes as a checksum.

Once the checksum byte is on the transmit port, the block waits for the host's verdict. A zero byte means the host agrees. The block then presents the decoded command to a downstream powerline transmitter and holds it until that transmitter reports completion. After completion it sends a fixed ready byte. Any other verdict, or no verdict within the acknowledge timeout, makes the block drop the frame silently and return to listening. The host is expected to send the frame again.

The byte ports are a valid-only receive port and a valid/ready transmit port. The UART framing sits outside the block.

Top module: `pl_frame_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `tx_valid` and `cmd_valid` are low until a frame is received.
- R2: While idle, a received byte does not start a frame in any of these cases: bit 2 is clear, bits 7..3 hold a dim count above 22, or bit 0 is set and the byte is not exactly 0x07. Such a byte produces no transmit byte and no command.
- R3: A valid header with bit 0 clear starts a standard frame of two bytes (header, code). After the code byte arrives, the block offers on `tx_data` the sum of both bytes modulo 256.
- R4: The header 0x07 starts an extended frame of four bytes (header, code, data, command). The checksum offered is the modulo-256 sum of all four bytes.
- R5: In an extended frame, the low nibble of the code byte must be 0111. Otherwise the frame is dropped, no checksum is sent, and the block returns to idle.
- R6: A host reply of 0x00 after the checksum makes `cmd_valid` rise on the following clock edge. At that point the command fields are:
  - `cmd_house` = code[7:4]
  - `cmd_key` = code[3:0]
  - `cmd_func` = header[1]
  - `cmd_dim` = header[7:3]
  - `cmd_ext` = header[0]
  - `cmd_xdata` and `cmd_xcmd` = data and command bytes, zero for a standard frame.
- R7: `cmd_valid` and its fields stay stable until `cmd_done` is sampled high. The block then offers the ready byte 0x55 on the transmit port.
- R8: A host reply other than 0x00 produces no command and no ready byte. The block returns to idle, and a retransmitted frame is handled normally.
- R9: If no reply arrives within `ACK_TIMEOUT` cycles of the checksum transfer, the block returns to idle and sends nothing. A reply before the limit is still accepted.
- R10: A byte offered on the transmit port holds `tx_valid` and `tx_data` stable until `tx_ready` is sampled high.
- R11: Received bytes are ignored while the checksum, the command or the ready byte is pending. No new frame starts until the ready byte has been taken. `tx_valid` and `cmd_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe, one cycle per byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte (checksum or ready code) |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| cmd_valid | output | 1 | Command presented to the powerline transmitter |
| cmd_ext | output | 1 | Command is extended |
| cmd_func | output | 1 | Code byte is a function (1) or an address (0) |
| cmd_dim | output | 5 | Dim count from the header |
| cmd_house | output | 4 | Housecode nibble |
| cmd_key | output | 4 | Device or function nibble |
| cmd_xdata | output | 8 | Extended data byte |
| cmd_xcmd | output | 8 | Extended command byte |
| cmd_done | input | 1 | Powerline transmitter finished the command |

## Verification
The assertions check on every cycle that:
- offered transmit bytes and commands stay stable under backpressure;
- the transmit port and the command port never overlap;
- a command only ever rises right after a zero reply;
- every completed command is followed at once by the ready code;
- an extended command always carries function nibble 0111.

Only the bench scenarios can show the rest: the checksum values, the header and code filtering, the dropping of frames after a bad reply or a timeout (with a working retransmission afterwards), and the locking out of bytes during a pending exchange.

// File: rtl/plf_pkg.sv
package plf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATHER,
    ST_SUM,
    ST_AWAIT,
    ST_ISSUE,
    ST_READY
  } plf_state_t;

  localparam logic [7:0] READY_CODE = 8'h55;
  localparam logic [7:0] ACK_OK     = 8'h00;
  localparam logic [7:0] EXT_HEADER = 8'h07;
  localparam logic [3:0] EXT_FUNC   = 4'h7;
  localparam logic [4:0] DIM_MAX    = 5'd22;
  localparam int         FRAME_STD  = 2;
  localparam int         FRAME_EXT  = 4;

  typedef struct packed {
    logic [7:0] hdr;
    logic [7:0] code;
    logic [7:0] xdata;
    logic [7:0] xcmd;
  } plf_frame_t;

endpackage

// File: rtl/plf_rst_sync.sv
module plf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/plf_hdr_check.sv
module plf_hdr_check
  import plf_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       start_ok
);
  logic marker_ok;
  logic dim_ok;
  logic ext_ok;

  always_comb begin
    marker_ok = byte_i[2];
    dim_ok    = (byte_i[7:3] <= DIM_MAX);
    ext_ok    = !byte_i[0] || (byte_i == EXT_HEADER);
    start_ok  = marker_ok && dim_ok && ext_ok;
  end
endmodule

// File: rtl/plf_assembler.sv
module plf_assembler
  import plf_pkg::*;
#(
  parameter int MAX_BYTES = FRAME_EXT,
  localparam int IDX_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             load,
  input  logic [7:0]       byte_i,
  output plf_frame_t       frame,
  output logic [IDX_W-1:0] count,
  output logic [7:0]       sum
);
  logic [7:0]       slot_q [MAX_BYTES];
  logic [IDX_W-1:0] count_d, count_q;
  logic [7:0]       sum_d, sum_q;
  logic             en;

  assign en = start || load;

  always_comb begin
    count_d = count_q;
    sum_d   = sum_q;
    if (start) begin
      count_d = IDX_W'(1);
      sum_d   = byte_i;
    end else if (load) begin
      count_d = count_q + IDX_W'(1);
      sum_d   = sum_q + byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      sum_q   <= '0;
    end else if (en) begin
      count_q <= count_d;
      sum_q   <= sum_d;
    end
  end

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_slot
    logic       slot_en;
    logic [7:0] slot_d;
    always_comb begin
      slot_en = 1'b0;
      slot_d  = slot_q[i];
      if (start) begin
        slot_en = 1'b1;
        slot_d  = (i == 0) ? byte_i : 8'h00;
      end else if (load && (count_q == IDX_W'(i))) begin
        slot_en = 1'b1;
        slot_d  = byte_i;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[i] <= '0;
      else if (slot_en) slot_q[i] <= slot_d;
    end
  end

  assign frame = '{hdr: slot_q[0], code: slot_q[1], xdata: slot_q[2], xcmd: slot_q[3]};
  assign count = count_q;
  assign sum   = sum_q;
endmodule

// File: rtl/plf_ack_timer.sv
module plf_ack_timer #(
  parameter int LIMIT = 50_000_000,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt_d, cnt_q;

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pl_frame_ctrl.sv
module pl_frame_ctrl
  import plf_pkg::*;
#(
  parameter int ACK_TIMEOUT = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       cmd_valid,
  output logic       cmd_ext,
  output logic       cmd_func,
  output logic [4:0] cmd_dim,
  output logic [3:0] cmd_house,
  output logic [3:0] cmd_key,
  output logic [7:0] cmd_xdata,
  output logic [7:0] cmd_xcmd,
  input  logic       cmd_done
);
  localparam int IDX_W = $clog2(FRAME_EXT + 1);
  localparam logic [IDX_W-1:0] LAST_STD = IDX_W'(FRAME_STD - 1);
  localparam logic [IDX_W-1:0] LAST_EXT = IDX_W'(FRAME_EXT - 1);
  localparam logic [IDX_W-1:0] CODE_IDX = IDX_W'(1);

  logic             rst_i_n;
  plf_state_t       state_d, state_q;
  logic             start_ok;
  logic             asm_start, asm_load;
  plf_frame_t       frame;
  logic [IDX_W-1:0] count;
  logic [7:0]       sum;
  logic             timer_run, timer_expired;
  logic             frame_ext;
  logic [IDX_W-1:0] last_idx;

  plf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  plf_hdr_check u_hdr (
    .byte_i   (rx_data),
    .start_ok (start_ok)
  );

  plf_assembler #(.MAX_BYTES(FRAME_EXT)) u_asm (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .start  (asm_start),
    .load   (asm_load),
    .byte_i (rx_data),
    .frame  (frame),
    .count  (count),
    .sum    (sum)
  );

  plf_ack_timer #(.LIMIT(ACK_TIMEOUT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (timer_run),
    .expired (timer_expired)
  );

  assign frame_ext = frame.hdr[0] && frame.hdr[2];
  assign last_idx  = frame_ext ? LAST_EXT : LAST_STD;
  assign timer_run = (state_q == ST_AWAIT);

  always_comb begin
    state_d   = state_q;
    asm_start = 1'b0;
    asm_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rx_valid && start_ok) begin
          asm_start = 1'b1;
          state_d   = ST_GATHER;
        end
      end
      ST_GATHER: begin
        if (rx_valid) begin
          if (frame_ext && (count == CODE_IDX) && (rx_data[3:0] != EXT_FUNC)) begin
            state_d = ST_IDLE;
          end else begin
            asm_load = 1'b1;
            if (count == last_idx) state_d = ST_SUM;
          end
        end
      end
      ST_SUM: begin
        if (tx_ready) state_d = ST_AWAIT;
      end
      ST_AWAIT: begin
        if (rx_valid) begin
          state_d = (rx_data == ACK_OK) ? ST_ISSUE : ST_IDLE;
        end else if (timer_expired) begin
          state_d = ST_IDLE;
        end
      end
      ST_ISSUE: begin
        if (cmd_done) state_d = ST_READY;
      end
      ST_READY: begin
        if (tx_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  assign tx_valid  = (state_q == ST_SUM) || (state_q == ST_READY);
  assign tx_data   = (state_q == ST_READY) ? READY_CODE : sum;
  assign cmd_valid = (state_q == ST_ISSUE);
  assign cmd_ext   = frame_ext;
  assign cmd_func  = frame.hdr[1];
  assign cmd_dim   = frame.hdr[7:3];
  assign cmd_house = frame.code[7:4];
  assign cmd_key   = frame.code[3:0];
  assign cmd_xdata = frame.xdata;
  assign cmd_xcmd  = frame.xcmd;
endmodule

// File: rtl/plf_checker.sv
module plf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       cmd_valid,
  input logic       cmd_ext,
  input logic [3:0] cmd_house,
  input logic [3:0] cmd_key,
  input logic [7:0] cmd_xdata,
  input logic [7:0] cmd_xcmd,
  input logic       cmd_done
);
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable({cmd_house, cmd_key, cmd_xdata, cmd_xcmd}));

  a_r6_cmd_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(rx_valid && (rx_data == 8'h00)));

  a_r7_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_valid) |-> tx_valid && (tx_data == 8'h55));

  a_r11_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && cmd_valid));

  a_r5_ext_key: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ext |-> cmd_key == 4'h7);
endmodule

bind pl_frame_ctrl plf_checker u_plf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_data   (rx_data),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_ready  (tx_ready),
  .cmd_valid (cmd_valid),
  .cmd_ext   (cmd_ext),
  .cmd_house (cmd_house),
  .cmd_key   (cmd_key),
  .cmd_xdata (cmd_xdata),
  .cmd_xcmd  (cmd_xcmd),
  .cmd_done  (cmd_done)
);

// File: tb/tb_pl_frame_ctrl.sv
module tb_pl_frame_ctrl;
  localparam int TMO = 40;

  logic       clk;
  logic       rst_n;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready;
  logic       cmd_valid, cmd_ext, cmd_func;
  logic [4:0] cmd_dim;
  logic [3:0] cmd_house, cmd_key;
  logic [7:0] cmd_xdata, cmd_xcmd;
  logic       cmd_done;

  int checks = 0;
  int errors = 0;

  pl_frame_ctrl #(.ACK_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .cmd_valid(cmd_valid), .cmd_ext(cmd_ext), .cmd_func(cmd_func),
    .cmd_dim(cmd_dim), .cmd_house(cmd_house), .cmd_key(cmd_key),
    .cmd_xdata(cmd_xdata), .cmd_xcmd(cmd_xcmd), .cmd_done(cmd_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic take_tx(input logic [7:0] exp, input int hold, input string tag);
    int n = 0;
    while (!tx_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(tx_valid === 1'b1, {tag, " tx_valid"}, 32'(tx_valid), 1);
    chk(tx_data === exp, {tag, " tx_data"}, 32'(tx_data), 32'(exp));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(tx_valid === 1'b1 && tx_data === exp, {tag, " hold"}, 32'(tx_data), 32'(exp));
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic take_cmd(input logic [31:0] exp, input string tag);
    logic [31:0] act;
    int n = 0;
    while (!cmd_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    act = {cmd_ext, cmd_func, 1'b0, cmd_dim, cmd_house, cmd_key, cmd_xdata, cmd_xcmd} ;
    chk(cmd_valid === 1'b1, {tag, " cmd_valid"}, 32'(cmd_valid), 1);
    chk(act === exp, {tag, " cmd fields"}, act, exp);
    repeat (2) @(negedge clk);
    chk(cmd_valid === 1'b1, {tag, " cmd held"}, 32'(cmd_valid), 1);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_valid || cmd_valid) hits++;
    end
    chk(hits == 0, {tag, " silent"}, 32'(hits), 0);
  endtask

  function automatic logic [31:0] fld(input logic [7:0] h, input logic [7:0] c,
                                      input logic [7:0] d, input logic [7:0] m);
    return {h[0], h[1], 1'b0, h[7:3], c, d, m};
  endfunction

  task automatic t_reset();
    chk(tx_valid === 1'b0 && cmd_valid === 1'b0, "R1 reset outputs",
        {tx_valid, cmd_valid}, 0);
  endtask

  task automatic t_ignored_headers();
    send_byte(8'h03); quiet(6, "R2 bit2 clear");
    send_byte(8'hBC); quiet(6, "R2 dim over 22");
    send_byte(8'h05); quiet(6, "R2 ext flag not 0x07");
  endtask

  task automatic t_standard();
    send_byte(8'h04); send_byte(8'h66);
    take_tx(8'h6A, 0, "R3 std checksum");
    send_byte(8'h00);
    take_cmd(fld(8'h04, 8'h66, 8'h00, 8'h00), "R6 std address");
    take_tx(8'h55, 0, "R7 ready");
  endtask

  task automatic t_extended();
    send_byte(8'h07); send_byte(8'h67); send_byte(8'h31); send_byte(8'hC2);
    take_tx(8'h61, 3, "R4 ext checksum wraps, R10 hold");
    send_byte(8'h00);
    take_cmd(fld(8'h07, 8'h67, 8'h31, 8'hC2), "R6 ext command");
    take_tx(8'h55, 2, "R7 ready after ext, R10 hold");
  endtask

  task automatic t_bad_ext_code();
    send_byte(8'h07); send_byte(8'h66);
    quiet(8, "R5 ext code nibble");
  endtask

  task automatic t_nack_retry();
    send_byte(8'h86); send_byte(8'h64);
    take_tx(8'hEA, 0, "R8 first checksum");
    send_byte(8'hE0);
    quiet(TMO + 10, "R8 nonzero reply");
    send_byte(8'h86); send_byte(8'h64);
    take_tx(8'hEA, 0, "R8 retry checksum");
    send_byte(8'h00);
    take_cmd(fld(8'h86, 8'h64, 8'h00, 8'h00), "R8 retry dim function");
    take_tx(8'h55, 0, "R8 retry ready");
  endtask

  task automatic t_timeout();
    send_byte(8'h04); send_byte(8'h6E);
    take_tx(8'h72, 0, "R9 checksum");
    repeat (TMO - 10) @(negedge clk);
    send_byte(8'h00);
    take_cmd(fld(8'h04, 8'h6E, 8'h00, 8'h00), "R9 late ack inside limit");
    take_tx(8'h55, 0, "R9 ready");
    send_byte(8'h04); send_byte(8'h6E);
    take_tx(8'h72, 0, "R9 second checksum");
    quiet(TMO + 10, "R9 timeout");
    send_byte(8'h00);
    quiet(8, "R9 ack after timeout");
  endtask

  task automatic t_lockout();
    send_byte(8'h04); send_byte(8'h6E);
    send_byte(8'h04); send_byte(8'h66);
    take_tx(8'h72, 0, "R11 checksum unaffected");
    send_byte(8'h00);
    send_byte(8'h04);
    take_cmd(fld(8'h04, 8'h6E, 8'h00, 8'h00), "R11 command unaffected");
    send_byte(8'h04); send_byte(8'h66);
    take_tx(8'h55, 0, "R11 ready");
    quiet(8, "R11 no frame from locked bytes");
  endtask

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = 8'h00; tx_ready = 1'b0; cmd_done = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ignored_headers();
    t_standard();
    t_extended();
    t_bad_ext_code();
    t_nack_retry();
    t_timeout();
    t_lockout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule